// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings an LCD panel interface up and down in a fixed order. It drives two outputs: a controller enable and a panel power. Going up, the controller enable is raised first, a fixed interval of system clock cycles follows, and only then is panel power applied. Going down, panel power is removed first, the same interval follows, and then the controller enable is dropped. With this ordering, panel power is never on while the controller is off.

A two-bit control value is written through a write strobe. The enable bit is the controller enable and the power bit is the panel power. The power bit only takes effect when the enable bit is also set. Writing the value starts a sequence towards it.

A blank pulse takes the outputs down to both-off and leaves the stored control value unchanged. An unblank pulse brings the outputs back to the stored value. If a request arrives while a sequence is running, it is held, and the block acts on it once it is idle again. The latest request replaces any held one. The nominal interval is 20 ms, which is 2,000,000 cycles at 100 MHz. A testbench can set the parameter to a short value.

Top module: `lcd_pwr_seq`

## Requirements
- R1: A synchronous active-high reset, even mid-sequence, drives en_o, pwr_o and busy_o low and clears the stored control value to 0.
- R2: From both outputs off, a target with enable=1 and power=1 raises en_o one edge after the request. pwr_o then rises exactly WAIT_CYCLES edges later.
- R3: From both outputs on, a target with enable=0 drops pwr_o one edge after the request. en_o then falls exactly WAIT_CYCLES edges later.
- R4: When the target has enable=0 and pwr_o is already low, en_o is cleared on the edge after the request, with no wait and with busy_o staying low.
- R5: When both outputs are already off, a request for enable=0 changes nothing and busy_o stays low.
- R6: A blank pulse runs the power-down order and does not alter the stored value. A later unblank pulse runs the power-up order towards that stored value.
- R7: A request taken while busy_o is high leaves the outputs untouched until the running sequence ends. It is then acted on at the next edge, and when several requests are held, the latest one wins.
- R8: The power bit is ignored when the enable bit is 0. pwr_o is never high while en_o is low.
- R9: From both outputs on, a target with enable=1 and power=0 drops pwr_o. After WAIT_CYCLES edges the sequence ends with en_o still high.
- R10: From both outputs off, a target with enable=1 and power=0 raises en_o on the next edge, with no wait and with busy_o staying low.
- R11: With en_o already high and pwr_o low, a target with power=1 still waits WAIT_CYCLES edges before pwr_o rises.
- R12: busy_o is high from the edge of the first output change of a timed sequence until the edge of its final output change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the control value; also requests a sequence |
| cfg_en | input | 1 | Control value enable bit (bit 1 of the stored value) |
| cfg_pwr | input | 1 | Control value power bit (bit 0 of the stored value) |
| blank | input | 1 | Request power-down to both-off |
| unblank | input | 1 | Request power-up to the stored value |
| en_o | output | 1 | Controller enable |
| pwr_o | output | 1 | Panel power |
| busy_o | output | 1 | A timed sequence is in progress |

## Verification
The sweep starts from every reachable output state (off, enable only, enable and power). From each start it applies every two-bit target and compares all three outputs on every cycle against an arithmetic model. This separates the timed power-up and power-down paths from the immediate single-step cases and from the no-change cases. It also shows whether the power bit is masked when the enable bit is clear. Separate runs cover the following:
- a blank and unblank pair, which tells whether the stored value survives blanking;
- a burst of writes during a sequence, which tells deferral and latest-wins apart from immediate action;
- a reset in mid-sequence.

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq #(
  parameter int unsigned WAIT_CYCLES = 2_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_wr,
  input  logic cfg_en,
  input  logic cfg_pwr,
  input  logic blank,
  input  logic unblank,
  output logic en_o,
  output logic pwr_o,
  output logic busy_o
);

  localparam int CW = $clog2(WAIT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_UP, S_DN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [1:0]    stored, stored_nx, req_t, go_t, pend_t;
  logic          pend_v, keep_en, req, go, tgt_en, tgt_pw, last;

  assign stored_nx = cfg_wr ? {cfg_en, cfg_pwr} : stored;
  assign req       = cfg_wr | blank | unblank;
  assign req_t     = blank ? 2'b00 : stored_nx;
  assign go        = (st == S_IDLE) && (req || pend_v);
  assign go_t      = req ? req_t : pend_t;
  assign tgt_en    = go_t[1];
  assign tgt_pw    = go_t[1] & go_t[0];
  assign last      = (cnt == LAST);
  assign busy_o    = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      stored  <= 2'b00;
      pend_v  <= 1'b0;
      pend_t  <= 2'b00;
      keep_en <= 1'b0;
      en_o    <= 1'b0;
      pwr_o   <= 1'b0;
    end else begin
      stored <= stored_nx;
      if (st != S_IDLE && req) begin
        pend_v <= 1'b1;
        pend_t <= req_t;
      end
      case (st)
        S_IDLE: if (go) begin
          pend_v <= 1'b0;
          cnt    <= '0;
          if (tgt_en) begin
            en_o <= 1'b1;
            if (tgt_pw && !pwr_o) begin
              st <= S_UP;
            end else if (!tgt_pw && pwr_o) begin
              pwr_o   <= 1'b0;
              keep_en <= 1'b1;
              st      <= S_DN;
            end
          end else if (pwr_o) begin
            pwr_o   <= 1'b0;
            keep_en <= 1'b0;
            st      <= S_DN;
          end else begin
            en_o <= 1'b0;
          end
        end
        S_UP: if (last) begin
          pwr_o <= 1'b1;
          st    <= S_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_DN: if (last) begin
          en_o <= keep_en;
          st   <= S_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] up_run;
  always_ff @(posedge clk) begin
    if (rst || !(en_o && !pwr_o)) up_run <= '0;
    else if (up_run != CW'(WAIT_CYCLES)) up_run <= up_run + 1'b1;
  end

  a_r8_pwr_needs_en: assert property (@(posedge clk) disable iff (rst)
    pwr_o |-> en_o);
  a_r2_up_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_o) |-> (up_run >= CW'(WAIT_CYCLES)));
  a_r3_en_outlives_pwr: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_o) |=> en_o);
  a_r12_busy_before_pwr: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_o) |-> $past(busy_o));
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!en_o && !pwr_o && !busy_o));

endmodule

// File: tb/test_lcd_pwr_seq.sv
module test_lcd_pwr_seq;
  localparam int D = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_wr = 1'b0, cfg_en = 1'b0, cfg_pwr = 1'b0, blank = 1'b0, unblank = 1'b0;
  logic en_o, pwr_o, busy_o;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  lcd_pwr_seq #(.WAIT_CYCLES(D)) i_lcd_pwr_seq (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_pwr(cfg_pwr),
    .blank(blank), .unblank(unblank), .en_o(en_o), .pwr_o(pwr_o), .busy_o(busy_o));

  task automatic chk(string r, string what, logic a, logic e);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", r, what, a, e);
    end
  endtask

  task automatic chk3(string r, logic xe, logic xp, logic xb);
    chk(r, "en_o", en_o, xe);
    chk(r, "pwr_o", pwr_o, xp);
    chk(r, "busy_o", busy_o, xb);
  endtask

  task automatic put(logic w, logic e, logic p, logic b, logic u);
    cfg_wr = w; cfg_en = e; cfg_pwr = p; blank = b; unblank = u;
    @(negedge clk);
    cfg_wr = 0; blank = 0; unblank = 0;
  endtask

  task automatic settle();
    repeat (D + 4) @(negedge clk);
  endtask

  function automatic string tag_of(logic e0, logic p0, logic et, logic pi);
    logic pt = pi & et;
    if (!et && pi) return "R8";
    if (et && pt && !p0) return e0 ? "R11" : "R2";
    if (et && !pt && p0) return "R9";
    if (et && !pt && !e0) return "R10";
    if (!et && p0) return "R3";
    if (!et && e0) return "R4";
    if (!et) return "R5";
    return "R12";
  endfunction

  task automatic trace(string r, logic e0, logic p0, logic et, logic pi);
    logic pt = pi & et;
    for (int c = 1; c <= D + 3; c++) begin
      logic xe, xp, xb;
      if (et) begin
        xe = 1'b1;
        if (pt != p0) begin
          xp = pt ? (c >= 1 + D) : 1'b0;
          xb = (c < 1 + D);
        end else begin
          xp = p0; xb = 1'b0;
        end
      end else if (p0) begin
        xp = 1'b0; xe = (c < 1 + D); xb = (c < 1 + D);
      end else begin
        xe = 1'b0; xp = 1'b0; xb = 1'b0;
      end
      chk3(r, xe, xp, xb);
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk3("R1", 1'b0, 1'b0, 1'b0);
    @(negedge clk);

    for (int s = 0; s < 3; s++) begin
      logic se = (s != 0);
      logic sp = (s == 2);
      for (int t = 0; t < 4; t++) begin
        logic te = t[1];
        logic tp = t[0];
        put(1, se, sp, 0, 0);
        settle();
        chk3("R12", se, sp, 1'b0);
        put(1, te, tp, 0, 0);
        trace(tag_of(se, sp, te, tp), se, sp, te, tp);
        settle();
      end
    end

    put(1, 1, 1, 0, 0); settle();
    put(0, 0, 0, 1, 0);
    trace("R6", 1'b1, 1'b1, 1'b0, 1'b0);
    settle();
    put(0, 0, 0, 0, 1);
    trace("R6", 1'b0, 1'b0, 1'b1, 1'b1);
    settle();

    put(1, 0, 0, 0, 0); settle();
    put(1, 1, 1, 0, 0);
    chk3("R7", 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    put(1, 0, 0, 0, 0);
    put(1, 1, 0, 0, 0);
    chk3("R7", 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chk3("R7", 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    chk3("R7", 1'b1, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    chk3("R7", 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chk3("R7", 1'b1, 1'b0, 1'b0);
    settle();

    put(1, 1, 1, 0, 0);
    chk3("R1", 1'b1, 1'b0, 1'b1);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk3("R1", 1'b0, 1'b0, 1'b0);
    put(0, 0, 0, 0, 1);
    settle();
    chk3("R1", 1'b0, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule